// File: doc/BRIEF.md
# Synchronous SRAM Sleep-Mode Controller

This block supervises the low-power sleep state of a synchronous burst SRAM model. A free-running sleep request arrives with no relation to the clock. The block brings it into the clock domain through a chain of flops. While the synchronized request is high, the block masks the decoded cycle type seen by the memory core, closes the input gate and forces the data outputs to high impedance. The memory array is held outside this block, and the block never clears it.

When the request drops, a wake-up window of `WAKE_CYC` clock cycles opens. Inside that window only deselect and read cycles are legal. A write or a burst-continue cycle sampled inside the window sets a sticky violation flag, which only reset clears. On entry to sleep, the block samples the core's pending-operation indication. If an operation was still in flight, the block raises a one-cycle aborted pulse, because that operation cannot be trusted to have completed.

The block carries no data stream, so there is no valid/ready interface and no back-pressure. Every pin is a plain control or status level, or a one-cycle pulse.

Top module: `sram_sleep_ctrl`

## Requirements
- R1: After reset, and until the first sleep request is synchronized: `asleep`=0, `in_gate_en`=1, `out_hiz`=0, `waking`=0, `viol`=0, `aborted`=0, and `cyc_out` equals `cyc_in`.
- R2: `asleep` rises at the second rising clock edge after `sleep_req` goes high and falls at the second edge after it goes low. It stays high for as long as the request stays high.
- R3: While `asleep`=1, `in_gate_en`=0 and `cyc_out` is forced to deselect (2'b00) whatever `cyc_in` carries. Cycle codes are: 2'b00 deselect, 2'b01 read, 2'b10 write, 2'b11 burst-continue.
- R4: While `asleep`=1, `out_hiz`=1. While awake, `out_hiz`=0.
- R5: `waking` goes high in the first cycle after `asleep` falls and stays high for exactly `WAKE_CYC` cycles. It is never high while `asleep`=1.
- R6: A write (2'b10) or burst-continue (2'b11) cycle sampled at an edge while `waking`=1 sets `viol` from the next cycle on. `viol` then stays high until reset. A deselect (2'b00) or read (2'b01) cycle inside the window leaves `viol` at 0.
- R7: A cycle sampled while asleep, or after the window has closed, never sets `viol`, whatever its code.
- R8: `aborted` pulses high for exactly one cycle, the first cycle with `asleep`=1, if and only if `op_pending` was high at the edge where `asleep` rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| cyc_in | input | 2 | Decoded cycle type from the command decoder |
| op_pending | input | 1 | High while an operation is still in flight in the core |
| cyc_out | output | 2 | Cycle type passed to the core, forced to deselect while asleep |
| asleep | output | 1 | Synchronized sleep state |
| in_gate_en | output | 1 | High when core inputs may be taken |
| out_hiz | output | 1 | High when the data outputs must be tristated |
| waking | output | 1 | High during the wake-up window |
| viol | output | 1 | Sticky flag: illegal cycle issued inside the wake-up window |
| aborted | output | 1 | One-cycle pulse: an operation was pending when sleep was entered |

## Verification
The sleep state is due two edges after the request changes. `aborted` appears in that same first asleep cycle, and `viol` is due one edge after the offending cycle is sampled. `in_gate_en`, `out_hiz` and `cyc_out` follow `asleep` in the same cycle. The bench drives inputs and samples outputs 1 ns after each rising edge, and counts edges from the stimulus to the cycle where each result is due. It sweeps all four cycle codes against every offset from the start of the wake-up window to two cycles past its end. For each case it checks that `viol` appears one edge later and then holds.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
  typedef enum logic [1:0] {
    CYC_DESEL = 2'b00,
    CYC_READ  = 2'b01,
    CYC_WRITE = 2'b10,
    CYC_BURST = 2'b11
  } cyc_e;

  function automatic logic cyc_legal_waking(input cyc_e c);
    return (c == CYC_DESEL) || (c == CYC_READ);
  endfunction
endpackage

// File: rtl/ssc_sync.sv
module ssc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync,
  output logic q_early
);
  logic [STAGES-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= 1'b0;
    else        stg[0] <= d_async;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= 1'b0;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q_sync  = stg[STAGES-1];
  assign q_early = stg[STAGES-2];
endmodule

// File: rtl/ssc_wake_timer.sv
module ssc_wake_timer #(
  parameter int WAKE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic asleep,
  output logic waking
);
  localparam int CW = $clog2(WAKE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(WAKE_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (asleep)     cnt <= LOAD;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign waking = !asleep && (cnt != '0);
endmodule

// File: rtl/ssc_guard.sv
module ssc_guard
  import sleep_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic waking,
  input  cyc_e cyc,
  input  logic entering,
  input  logic op_pending,
  output logic viol,
  output logic aborted
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol    <= 1'b0;
      aborted <= 1'b0;
    end else begin
      if (waking && !cyc_legal_waking(cyc)) viol <= 1'b1;
      aborted <= entering && op_pending;
    end
  end
endmodule

// File: rtl/sram_sleep_ctrl.sv
module sram_sleep_ctrl
  import sleep_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WAKE_CYC    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic [1:0] cyc_in,
  input  logic       op_pending,
  output logic [1:0] cyc_out,
  output logic       asleep,
  output logic       in_gate_en,
  output logic       out_hiz,
  output logic       waking,
  output logic       viol,
  output logic       aborted
);
  logic req_early;
  logic entering;
  cyc_e cyc_dec;

  ssc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(sleep_req),
    .q_sync(asleep), .q_early(req_early)
  );

  ssc_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .asleep(asleep), .waking(waking)
  );

  assign cyc_dec  = cyc_e'(cyc_in);
  assign entering = req_early && !asleep;

  ssc_guard u_guard (
    .clk(clk), .rst_n(rst_n), .waking(waking), .cyc(cyc_dec),
    .entering(entering), .op_pending(op_pending),
    .viol(viol), .aborted(aborted)
  );

  assign in_gate_en = !asleep;
  assign out_hiz    = asleep;
  assign cyc_out    = asleep ? CYC_DESEL : cyc_in;
endmodule

// File: rtl/ssc_checker.sv
module ssc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cyc_in,
  input logic [1:0] cyc_out,
  input logic       asleep,
  input logic       in_gate_en,
  input logic       out_hiz,
  input logic       waking,
  input logic       viol,
  input logic       aborted
);
  AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> (!in_gate_en && cyc_out == 2'b00)); // R3
  AST_GATE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !asleep |-> (in_gate_en && cyc_out == cyc_in)); // R1
  AST_HIZ_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> out_hiz); // R4
  AST_WAKE_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    waking |-> !asleep); // R5
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> viol); // R6
  AST_VIOL_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (!waking && !viol) |=> !viol); // R7
  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    aborted |=> !aborted); // R8
  AST_ABORT_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    aborted |-> asleep); // R8
endmodule

bind sram_sleep_ctrl ssc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_in(cyc_in), .cyc_out(cyc_out),
  .asleep(asleep), .in_gate_en(in_gate_en), .out_hiz(out_hiz),
  .waking(waking), .viol(viol), .aborted(aborted)
);

// File: tb/sim_sram_sleep_ctrl.sv
`timescale 1ns/1ps
module sim_sram_sleep_ctrl;
  localparam int W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0;
  logic [1:0] cyc_in = 2'b00;
  logic op_pending = 1'b0;
  logic [1:0] cyc_out;
  logic asleep, in_gate_en, out_hiz, waking, viol, aborted;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  sram_sleep_ctrl #(.SYNC_STAGES(2), .WAKE_CYC(W)) u0 (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .cyc_in(cyc_in),
    .op_pending(op_pending), .cyc_out(cyc_out), .asleep(asleep),
    .in_gate_en(in_gate_en), .out_hiz(out_hiz), .waking(waking),
    .viol(viol), .aborted(aborted)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sleep_req = 1'b0;
    op_pending = 1'b0;
    cyc_in = 2'b00;
    tick();
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic go_sleep(input logic pend);
    sleep_req = 1'b1;
    op_pending = pend;
    tick();
    chk("R2 asleep after one edge", int'(asleep), 0);
    tick();
    chk("R2 asleep after two edges", int'(asleep), 1);
    chk("R8 aborted on entry", int'(aborted), int'(pend));
    op_pending = 1'b0;
    tick();
    chk("R8 aborted single cycle", int'(aborted), 0);
    chk("R3 input gate closed", int'(in_gate_en), 0);
    chk("R4 outputs tristated", int'(out_hiz), 1);
    chk("R5 no window while asleep", int'(waking), 0);
  endtask

  task automatic wake();
    sleep_req = 1'b0;
    tick();
    chk("R2 still asleep one edge after release", int'(asleep), 1);
    tick();
    chk("R2 awake two edges after release", int'(asleep), 0);
    chk("R4 outputs driven when awake", int'(out_hiz), 0);
    chk("R5 window opens", int'(waking), 1);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    cyc_in = 2'b01;
    #1;
    chk("R1 asleep", int'(asleep), 0);
    chk("R1 in_gate_en", int'(in_gate_en), 1);
    chk("R1 out_hiz", int'(out_hiz), 0);
    chk("R1 waking", int'(waking), 0);
    chk("R1 viol", int'(viol), 0);
    chk("R1 aborted", int'(aborted), 0);
    chk("R1 cyc_out passes", int'(cyc_out), 1);
    cyc_in = 2'b00;

    // long hold and window length
    go_sleep(1'b0);
    for (int i = 0; i < 20; i++) begin
      tick();
      chk("R2 held asleep", int'(asleep), 1);
    end
    wake();
    begin
      int cnt = 1;
      for (int i = 0; i < W + 3; i++) begin
        tick();
        if (waking) cnt++;
      end
      chk("R5 window length", cnt, W);
    end

    // sweep cycle code against window offset
    for (int t = 0; t < 4; t++) begin
      for (int k = 0; k <= W + 1; k++) begin
        bit in_win;
        bit exp_v;
        do_reset();
        go_sleep(logic'(t[0]));
        cyc_in = 2'(t);
        tick();
        tick();
        chk("R3 cyc masked while asleep", int'(cyc_out), 0);
        cyc_in = 2'b00;
        tick();
        chk("R7 no viol from asleep cycle", int'(viol), 0);
        wake();
        for (int j = 0; j < k; j++) tick();
        in_win = (k < W);
        chk("R5 window at offset", int'(waking), int'(in_win));
        cyc_in = 2'(t);
        tick();
        cyc_in = 2'b00;
        exp_v = in_win && (t >= 2);
        chk(in_win ? "R6 viol after window cycle" : "R7 viol after window closed",
            int'(viol), int'(exp_v));
        for (int j = 0; j < W + 2; j++) tick();
        chk("R6 viol sticky", int'(viol), int'(exp_v));
        chk("R5 window closed", int'(waking), 0);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule